// File: doc/BRIEF.md
# Address-Window Trace Gate

This block sits beside an instruction-retire stream and decides, for every retired instruction, whether its trace is passed on to a downstream trace encoder. It looks only at the program-counter value of each instruction. Two independent filters are combined. The first is a set of inclusive address windows. The second is a start/stop state that is driven by single-address start and stop points.

Every window and every point is loaded through a narrow register-write port, and each entry carries its own enable bit. The filters are permissive when nothing is armed. If no window is enabled, the window filter passes everything. If no start point is enabled, the start/stop state counts as active. Start and stop points do not nest, so the first stop that is hit closes tracing however many starts came before it. The decision is registered, so it appears one clock after the instruction is presented.

Top module: `trace_addr_gate`

## Requirements
- R1: While no address window is enabled, the window filter passes every valid instruction.
- R2: While at least one window is enabled, an instruction passes the window filter only if lo <= pc <= hi holds for some enabled window, with both bounds inclusive. A callee outside every window is therefore dropped, even when its caller lies inside a window.
- R3: While no start point is enabled, the start/stop state is active for every instruction, whatever stop points are enabled.
- R4: While any start point is enabled, the state is inactive after reset and after any write with cfg_kind 2 or 3. An instruction whose pc equals an enabled start address makes the state active, and that instruction is itself traced.
- R5: While any start point is enabled, an instruction whose pc equals an enabled stop address is not traced, and the state is inactive afterwards. The points do not nest: two starts followed by one stop leave tracing off.
- R6: When one pc matches both an enabled start point and an enabled stop point, the stop takes priority. The instruction is not traced and the state becomes inactive.
- R7: trc_vld equals ins_vld delayed by one clock. trc_en equals, one clock later, ins_vld AND the window result AND the start/stop result. trc_en is never high while trc_vld is low.
- R8: A write with cfg_we=1 updates entry cfg_idx as selected by cfg_kind: 0 loads the window low bound, 1 loads the window high bound, 2 loads a start point, and 3 loads a stop point. The entry's enable bit is loaded from cfg_on on the same write. For a window, either bound write sets that enable. An instruction presented in the same cycle as a write still sees the old configuration.
- R9: During reset both outputs are low and every entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target of the write: 0 window low, 1 window high, 2 start point, 3 stop point |
| cfg_idx | input | IDX_W | Entry index |
| cfg_addr | input | ADDR_W | Address value to load |
| cfg_on | input | 1 | Enable bit loaded into the entry |
| ins_vld | input | 1 | A retired instruction is presented |
| ins_pc | input | ADDR_W | Program counter of that instruction |
| trc_vld | output | 1 | Registered copy of ins_vld |
| trc_en | output | 1 | Trace enable for the instruction presented one clock earlier |

## Verification
The bench drives the block with addresses at exactly lo and hi of a window and one step outside them. A design with an off-by-one comparison would either drop the boundary instructions or leak their neighbours. It plays two starts followed by a single stop, and checks that tracing ends at that first stop; a design that counts nesting would keep tracing. It also places a start and a stop on the same address, where a design that gives the start priority would trace an instruction it should drop. Finally, it enables a start point after tracing has been free-running and confirms that the state begins closed, which catches a design whose state register carries stale state.

// File: rtl/trace_addr_gate.sv
module trace_addr_gate #(
  parameter int ADDR_W  = 32,
  parameter int N_RANGE = 4,
  parameter int N_POINT = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_on,
  input  logic              ins_vld,
  input  logic [ADDR_W-1:0] ins_pc,
  output logic              trc_vld,
  output logic              trc_en
);
  logic [ADDR_W-1:0] rlo [N_RANGE];
  logic [ADDR_W-1:0] rhi [N_RANGE];
  logic [ADDR_W-1:0] spt [N_POINT];
  logic [ADDR_W-1:0] ept [N_POINT];
  logic [N_RANGE-1:0] ren, rin;
  logic [N_POINT-1:0] sen, een, shit, ehit;
  logic armed_q;

  for (genvar g = 0; g < N_RANGE; g++) begin : g_rng
    assign rin[g] = ren[g] && (ins_pc >= rlo[g]) && (ins_pc <= rhi[g]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rlo[g] <= '0;
        rhi[g] <= '0;
        ren[g] <= 1'b0;
      end else if (cfg_we && !cfg_kind[1] && int'(cfg_idx) == g) begin
        if (cfg_kind[0]) rhi[g] <= cfg_addr;
        else             rlo[g] <= cfg_addr;
        ren[g] <= cfg_on;
      end
    end
  end

  for (genvar p = 0; p < N_POINT; p++) begin : g_pt
    assign shit[p] = sen[p] && (ins_pc == spt[p]);
    assign ehit[p] = een[p] && (ins_pc == ept[p]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        spt[p] <= '0;
        ept[p] <= '0;
        sen[p] <= 1'b0;
        een[p] <= 1'b0;
      end else if (cfg_we && cfg_kind[1] && int'(cfg_idx) == p) begin
        if (cfg_kind[0]) begin
          ept[p] <= cfg_addr;
          een[p] <= cfg_on;
        end else begin
          spt[p] <= cfg_addr;
          sen[p] <= cfg_on;
        end
      end
    end
  end

  logic rng_any, range_ok, starts_any, start_hit, stop_hit, gate_now;
  assign rng_any    = |ren;
  assign range_ok   = !rng_any || (|rin);
  assign starts_any = |sen;
  assign start_hit  = |shit;
  assign stop_hit   = |ehit;
  assign gate_now   = !starts_any || (!stop_hit && (start_hit || armed_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trc_vld <= 1'b0;
      trc_en  <= 1'b0;
    end else begin
      if (cfg_we && cfg_kind[1])  armed_q <= 1'b0;
      else if (ins_vld) begin
        if (stop_hit)             armed_q <= 1'b0;
        else if (start_hit)       armed_q <= 1'b1;
      end
      trc_vld <= ins_vld;
      trc_en  <= ins_vld && range_ok && gate_now;
    end
  end
endmodule

// File: rtl/trace_addr_gate_chk.sv
module trace_addr_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic ins_vld,
  input logic trc_vld,
  input logic trc_en,
  input logic rng_any,
  input logic range_ok,
  input logic starts_any,
  input logic start_hit,
  input logic stop_hit
);
  AST_EN_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    trc_en |-> trc_vld); // R7
  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld |=> trc_vld); // R7
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && !rng_any && !starts_any |=> trc_en); // R1
  AST_OUTSIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && !range_ok |=> !trc_en); // R2
  AST_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && starts_any && stop_hit |=> !trc_en); // R5
  AST_START_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && range_ok && start_hit && !stop_hit |=> trc_en); // R4
endmodule

bind trace_addr_gate trace_addr_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .trc_vld(trc_vld), .trc_en(trc_en),
  .rng_any(rng_any), .range_ok(range_ok), .starts_any(starts_any),
  .start_hit(start_hit), .stop_hit(stop_hit)
);

// File: tb/trace_addr_gate_tb.sv
module trace_addr_gate_tb;
  localparam int AW = 32;
  localparam int NR = 4;
  localparam int NP = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_on = 0, ins_vld = 0;
  logic [1:0] cfg_kind = 0, cfg_idx = 0;
  logic [AW-1:0] cfg_addr = 0, ins_pc = 0;
  logic trc_vld, trc_en;

  always #5 clk = ~clk;

  trace_addr_gate #(.ADDR_W(AW), .N_RANGE(NR), .N_POINT(NP), .IDX_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_on(cfg_on), .ins_vld(ins_vld), .ins_pc(ins_pc),
    .trc_vld(trc_vld), .trc_en(trc_en));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_lo [NR], m_hi [NR], m_sp [NP], m_ep [NP];
  bit m_ren [NR], m_sen [NP], m_een [NP];
  bit m_arm;

  function automatic bit f_range(input logic [AW-1:0] pc);
    bit any = 0, hit = 0;
    for (int i = 0; i < NR; i++) if (m_ren[i]) begin
      any = 1;
      if (pc >= m_lo[i] && pc <= m_hi[i]) hit = 1;
    end
    return !any || hit;
  endfunction

  function automatic bit f_starts();
    bit a = 0;
    for (int i = 0; i < NP; i++) if (m_sen[i]) a = 1;
    return a;
  endfunction

  function automatic bit f_shit(input logic [AW-1:0] pc);
    bit h = 0;
    for (int i = 0; i < NP; i++) if (m_sen[i] && m_sp[i] == pc) h = 1;
    return h;
  endfunction

  function automatic bit f_ehit(input logic [AW-1:0] pc);
    bit h = 0;
    for (int i = 0; i < NP; i++) if (m_een[i] && m_ep[i] == pc) h = 1;
    return h;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit we, input logic [1:0] kind, input logic [1:0] idx,
                      input logic [AW-1:0] addr, input bit on, input bit vld, input logic [AW-1:0] pc);
    bit e_en;
    bit sh, eh;
    cfg_we = we; cfg_kind = kind; cfg_idx = idx; cfg_addr = addr; cfg_on = on;
    ins_vld = vld; ins_pc = pc;
    sh = f_shit(pc); eh = f_ehit(pc);
    e_en = vld && f_range(pc) && (!f_starts() || (!eh && (sh || m_arm)));
    if (we) begin
      case (kind)
        2'd0: begin m_lo[idx] = addr; m_ren[idx] = on; end
        2'd1: begin m_hi[idx] = addr; m_ren[idx] = on; end
        2'd2: begin m_sp[idx] = addr; m_sen[idx] = on; end
        default: begin m_ep[idx] = addr; m_een[idx] = on; end
      endcase
    end
    if (we && kind[1]) m_arm = 0;
    else if (vld) begin
      if (eh) m_arm = 0;
      else if (sh) m_arm = 1;
    end
    @(negedge clk);
    check({tag, " R7 vld"}, trc_vld, vld);
    check(tag, trc_en, e_en);
  endtask

  task automatic wr(input logic [1:0] kind, input logic [1:0] idx, input logic [AW-1:0] a, input bit on);
    step("R8", 1, kind, idx, a, on, 0, 0);
  endtask

  task automatic ins(input string tag, input logic [AW-1:0] pc);
    step(tag, 0, 0, 0, 0, 0, 1, pc);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 2'(i), 0, 0);
      wr(2'd2, 2'(i), 0, 0);
      wr(2'd3, 2'(i), 0, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_ren[i] = 0; end
    for (int i = 0; i < NP; i++) begin m_sp[i] = 0; m_ep[i] = 0; m_sen[i] = 0; m_een[i] = 0; end
    m_arm = 0;
    ins_vld = 1; ins_pc = 5;
    repeat (3) @(negedge clk);
    check("R9 vld", trc_vld, 0);
    check("R9 en", trc_en, 0);
    rst_n = 1;

    // R1 / R3: nothing configured, everything traced
    ins("R1", 0); ins("R1", 32'hFFFF_FFFF); ins("R3", 77);
    // R3: stop point without any start point has no effect
    wr(2'd3, 0, 10, 1);
    ins("R3", 10); ins("R3", 11);
    wr(2'd3, 0, 0, 0);
    // R2: inclusive bounds, callee outside dropped
    wr(2'd0, 1, 20, 1); wr(2'd1, 1, 30, 1);
    ins("R2 below", 19); ins("R2 lo", 20); ins("R2 hi", 30); ins("R2 above", 31);
    ins("R2 callee", 500); ins("R2 back", 25);
    // R8: write and instruction in same cycle sees old config
    step("R8", 1, 2'd0, 1, 0, 0, 1, 500);
    ins("R8 after", 500);
    // R4: start point armed after free running begins closed
    wr(2'd2, 2, 40, 1);
    ins("R4 closed", 41); ins("R4 start", 40); ins("R4 open", 41);
    // R5: two starts one stop, no nesting
    wr(2'd2, 3, 50, 1); wr(2'd3, 1, 60, 1);
    ins("R4 closed", 42); ins("R4 s1", 40); ins("R4 s2", 50);
    ins("R5 stop", 60); ins("R5 after", 42); ins("R5 after", 43);
    // R6: same address start and stop
    wr(2'd3, 2, 40, 1);
    ins("R6 both", 40); ins("R6 after", 41);
    ins("R4 s", 50); ins("R6 both", 40); ins("R6 after", 41);
    clear_all();

    // randomized mix
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      if (r < 6) begin
        logic [AW-1:0] a = $urandom_range(0, 63), b = $urandom_range(0, 63);
        logic [1:0] k = 2'($urandom_range(0, 3));
        if (k == 2'd1 && a < 32) a = a + 32;
        step("R8 rnd", 1, k, 2'($urandom_range(0, 3)), a, ($urandom_range(0, 2) != 0),
             $urandom_range(0, 1), b);
      end else if (r < 8) begin
        clear_all();
      end else begin
        step("R7 rnd", 0, 0, 0, 0, 0, ($urandom_range(0, 5) != 0), $urandom_range(0, 63));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule